// File: doc/BRIEF.md
# Reset Source and Status-Flag Controller

This block merges three reset requests into a single synchronous core reset: the power-on input, the active-low external master-clear pin, and the watchdog time-out pulse. The power-on input resets the block asynchronously and is released through a synchronizer. The master-clear pin is synchronized and then filtered, so short low glitches are ignored. After every request ends, the core reset stays asserted for a start-up hold time. That hold time is picked from four reference-clock counts by a static delay setting, checked against the static oscillator type.

The block keeps two status flags that firmware reads after reset to find what woke it. The time-out flag tells a watchdog reset apart from the other causes. The power-down flag records whether the core was asleep. Each reset cause, combined with the sleep indication, writes its own pair of flag values. The clear-watchdog and sleep instruction strobes also write the flags, and each one produces a one-cycle watchdog-clear pulse. The block also presents the fixed restart address that the program counter takes while the core is held in reset.

Top module: `rst_cause_ctrl`

## Requirements
- R1: While `por_n` is low, `core_rst` is 1, `to_flag` and `pd_flag` are both 1, and `wdt_clear` is 0.
- R2: After `por_n` rises, `core_rst` stays high for exactly SYNC_N + N rising edges, then falls. N is the effective start-up count of R7.
- R3: A low level on `mclr_pin_n` that is sampled on fewer than FILT_CYC consecutive edges causes no reset and leaves both flags unchanged.
- R4: When `mclr_pin_n` goes low, `core_rst` rises on the (FILT_CYC+3)-th edge that samples the low level. When the pin returns high, `core_rst` falls on the (N+3)-th edge that samples it high.
- R5: A master-clear reset changes no flag when `core_asleep` is 0. When `core_asleep` is 1, it sets `to_flag`=1 and `pd_flag`=0. The sleep indication is taken in the cycle the filtered request first asserts.
- R6: A `wdt_expire` pulse raises `core_rst` on that edge and clears `to_flag`. `pd_flag` becomes 1 if `core_asleep` is 0 and becomes 0 if it is 1. `core_rst` falls on the (N+1)-th edge counted from the pulse. The watchdog takes priority over a master-clear event in the same cycle.
- R7: `start_sel` codes 0,1,2,3 select the counts D_SHORT, D_20, D_40, D_80. `osc_kind` code 0 (RC) allows all four. Codes 2 (standard crystal) and 3 (high-frequency crystal) promote code 0 to code 1. Code 1 (low-frequency crystal) promotes codes 0 and 1 to code 2.
- R8: A `clrwdt_stb` outside reset sets both flags to 1 and raises `wdt_clear` for exactly one cycle, starting on the next edge. It takes priority over a `sleep_stb` in the same cycle.
- R9: A `sleep_stb` outside reset sets `to_flag`=1 and `pd_flag`=0 and raises `wdt_clear` for exactly one cycle, starting on the next edge.
- R10: While `core_rst` is high, `clrwdt_stb` and `sleep_stb` are ignored: the flags do not change and `wdt_clear` stays 0.
- R11: `boot_pc` always presents RST_VEC, which is 9'h1FF by default.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous assert |
| mclr_pin_n | input | 1 | External master-clear pin, active low, asynchronous to clk |
| wdt_expire | input | 1 | One-cycle watchdog time-out pulse |
| core_asleep | input | 1 | Core is in sleep mode |
| clrwdt_stb | input | 1 | Clear-watchdog instruction executed |
| sleep_stb | input | 1 | Sleep instruction executed |
| osc_kind | input | 2 | Oscillator type: 0 RC, 1 low-freq crystal, 2 standard crystal, 3 high-freq crystal |
| start_sel | input | 2 | Start-up delay code: 0 shortest ... 3 longest |
| core_rst | output | 1 | Synchronous core reset, active high |
| to_flag | output | 1 | Time-out status flag |
| pd_flag | output | 1 | Power-down status flag |
| wdt_clear | output | 1 | One-cycle watchdog clear pulse |
| boot_pc | output | PC_W | Program-counter restart address |

## Verification
Each result has a fixed latency, and the bench checks at that latency. Flag updates and the `wdt_clear` pulse appear one edge after a strobe or watchdog pulse. A filtered master clear reaches `core_rst` on edge FILT_CYC+3 after the first low sample. Release takes N+3 edges after the pin returns high, N+1 edges after a watchdog pulse, and SYNC_N+N edges after power-on. A behavioural model in the bench advances on each rising edge, and the outputs are compared against it in the middle of the cycle. Directed checks count the edges between the drive and the observed transition and compare that count with these formulas for several oscillator and delay combinations.

// File: rtl/rcc_pkg.sv
package rcc_pkg;

  typedef enum logic [1:0] {
    OSC_RC = 2'd0,
    OSC_LF = 2'd1,
    OSC_XT = 2'd2,
    OSC_HF = 2'd3
  } osc_kind_e;

  // Move a disallowed start-up code up to the nearest allowed longer one.
  function automatic logic [1:0] promote_sel(osc_kind_e kind, logic [1:0] sel);
    logic [1:0] eff;
    eff = sel;
    unique case (kind)
      OSC_RC:         eff = sel;
      OSC_LF:         if (sel < 2'd2) eff = 2'd2;
      OSC_XT, OSC_HF: if (sel == 2'd0) eff = 2'd1;
      default:        eff = sel;
    endcase
    return eff;
  endfunction

endpackage

// File: rtl/rcc_por_sync.sv
module rcc_por_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_ok
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign rst_ok = sh_q[STAGES-1];

endmodule

// File: rtl/rcc_clr_filter.sv
module rcc_clr_filter #(
  parameter int unsigned FILT_CYC = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic pin_n,
  output logic req
);

  localparam int unsigned CW = $clog2(FILT_CYC + 1);
  localparam logic [CW-1:0] RUN_MAX = CW'(FILT_CYC);

  logic [1:0]    pipe_q;
  logic          pin_sync;
  logic [CW-1:0] run_q;
  logic [CW-1:0] run_d;

  assign pin_sync = pipe_q[1];

  always_comb begin
    run_d = run_q;
    if (pin_sync)              run_d = '0;
    else if (run_q != RUN_MAX) run_d = run_q + 1'b1;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      pipe_q <= 2'b11;
      run_q  <= '0;
    end else begin
      pipe_q <= {pipe_q[0], pin_n};
      run_q  <= run_d;
    end
  end

  assign req = (run_q == RUN_MAX);

  // R3: a high synchronized pin level cancels any pending request
  a_r3_high_cancels: assert property (@(posedge clk) disable iff (!arst_n)
    pin_sync |=> !req);

endmodule

// File: rtl/rcc_hold_timer.sv
module rcc_hold_timer
  import rcc_pkg::*;
#(
  parameter int unsigned D_SHORT = 150,
  parameter int unsigned D_20    = 20000,
  parameter int unsigned D_40    = 40000,
  parameter int unsigned D_80    = 80000
) (
  input  logic       clk,
  input  logic       arst_n,
  input  logic       req,
  input  logic [1:0] osc_kind,
  input  logic [1:0] start_sel,
  output logic       hold
);

  localparam int unsigned M01  = (D_SHORT > D_20) ? D_SHORT : D_20;
  localparam int unsigned M23  = (D_40 > D_80) ? D_40 : D_80;
  localparam int unsigned DMAX = (M01 > M23) ? M01 : M23;
  localparam int unsigned CW   = $clog2(DMAX + 1);
  localparam int unsigned DLY [4] = '{D_SHORT, D_20, D_40, D_80};

  logic [CW-1:0] last_tab [4];
  logic [1:0]    sel_eff;
  logic [CW-1:0] last_cnt;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          hold_q, hold_d;

  for (genvar g = 0; g < 4; g++) begin : g_tab
    assign last_tab[g] = CW'(DLY[g] - 1);
  end

  assign sel_eff  = promote_sel(osc_kind_e'(osc_kind), start_sel);
  assign last_cnt = last_tab[sel_eff];

  always_comb begin
    hold_d = hold_q;
    cnt_d  = cnt_q;
    if (req) begin
      hold_d = 1'b1;
      cnt_d  = '0;
    end else if (hold_q) begin
      if (cnt_q == last_cnt) hold_d = 1'b0;
      else                   cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      hold_q <= 1'b1;
      cnt_q  <= '0;
    end else begin
      hold_q <= hold_d;
      cnt_q  <= cnt_d;
    end
  end

  assign hold = hold_q;

  // R6: any request puts the core into reset on the next edge
  a_r6_req_forces: assert property (@(posedge clk) disable iff (!arst_n)
    req |=> hold);
  // R4: reset is only released after a cycle with no request
  a_r4_quiet_release: assert property (@(posedge clk) disable iff (!arst_n)
    $fell(hold) |-> !$past(req));

endmodule

// File: rtl/rcc_flag_unit.sv
module rcc_flag_unit (
  input  logic clk,
  input  logic arst_n,
  input  logic mclr_req,
  input  logic wdt_expire,
  input  logic core_asleep,
  input  logic core_rst,
  input  logic clrwdt_stb,
  input  logic sleep_stb,
  output logic to_flag,
  output logic pd_flag,
  output logic wdt_clear
);

  logic mreq_q;
  logic mrise;
  logic to_q, to_d;
  logic pd_q, pd_d;
  logic wc_q, wc_d;
  logic run_ok;

  assign mrise  = mclr_req & ~mreq_q;
  assign run_ok = ~core_rst;

  always_comb begin
    to_d = to_q;
    pd_d = pd_q;
    if (wdt_expire) begin
      to_d = 1'b0;
      pd_d = ~core_asleep;
    end else if (mrise) begin
      if (core_asleep) begin
        to_d = 1'b1;
        pd_d = 1'b0;
      end
    end else if (run_ok && clrwdt_stb) begin
      to_d = 1'b1;
      pd_d = 1'b1;
    end else if (run_ok && sleep_stb) begin
      to_d = 1'b1;
      pd_d = 1'b0;
    end
    wc_d = run_ok & (clrwdt_stb | sleep_stb);
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      mreq_q <= 1'b0;
      to_q   <= 1'b1;
      pd_q   <= 1'b1;
      wc_q   <= 1'b0;
    end else begin
      mreq_q <= mclr_req;
      to_q   <= to_d;
      pd_q   <= pd_d;
      wc_q   <= wc_d;
    end
  end

  assign to_flag   = to_q;
  assign pd_flag   = pd_q;
  assign wdt_clear = wc_q;

  // R6: watchdog time-out always clears the time-out flag
  a_r6_wdt_to: assert property (@(posedge clk) disable iff (!arst_n)
    wdt_expire |=> !to_flag);
  // R8: clear-watchdog outside reset sets both flags and pulses the clear
  a_r8_clrwdt: assert property (@(posedge clk) disable iff (!arst_n)
    (clrwdt_stb && !core_rst && !wdt_expire && !mrise) |=> (to_flag && pd_flag && wdt_clear));
  // R9: sleep alone outside reset gives flag pair 1/0
  a_r9_sleep: assert property (@(posedge clk) disable iff (!arst_n)
    (sleep_stb && !clrwdt_stb && !core_rst && !wdt_expire && !mrise) |=> (to_flag && !pd_flag));
  // R10: no watchdog clear pulse is produced from a cycle held in reset
  a_r10_gated: assert property (@(posedge clk) disable iff (!arst_n)
    wdt_clear |-> !$past(core_rst));

endmodule

// File: rtl/rst_cause_ctrl.sv
module rst_cause_ctrl #(
  parameter int unsigned SYNC_N   = 2,
  parameter int unsigned FILT_CYC = 2,
  parameter int unsigned D_SHORT  = 150,
  parameter int unsigned D_20     = 20000,
  parameter int unsigned D_40     = 40000,
  parameter int unsigned D_80     = 80000,
  parameter int unsigned PC_W     = 9,
  parameter logic [PC_W-1:0] RST_VEC = 9'h1FF
) (
  input  logic            clk,
  input  logic            por_n,
  input  logic            mclr_pin_n,
  input  logic            wdt_expire,
  input  logic            core_asleep,
  input  logic            clrwdt_stb,
  input  logic            sleep_stb,
  input  logic [1:0]      osc_kind,
  input  logic [1:0]      start_sel,
  output logic            core_rst,
  output logic            to_flag,
  output logic            pd_flag,
  output logic            wdt_clear,
  output logic [PC_W-1:0] boot_pc
);

  logic rst_ok;
  logic mclr_req;
  logic any_req;

  rcc_por_sync #(.STAGES(SYNC_N)) i_sync (
    .clk    (clk),
    .arst_n (por_n),
    .rst_ok (rst_ok)
  );

  rcc_clr_filter #(.FILT_CYC(FILT_CYC)) i_filt (
    .clk    (clk),
    .arst_n (rst_ok),
    .pin_n  (mclr_pin_n),
    .req    (mclr_req)
  );

  assign any_req = mclr_req | wdt_expire;

  rcc_hold_timer #(
    .D_SHORT (D_SHORT),
    .D_20    (D_20),
    .D_40    (D_40),
    .D_80    (D_80)
  ) i_timer (
    .clk       (clk),
    .arst_n    (rst_ok),
    .req       (any_req),
    .osc_kind  (osc_kind),
    .start_sel (start_sel),
    .hold      (core_rst)
  );

  rcc_flag_unit i_flags (
    .clk         (clk),
    .arst_n      (rst_ok),
    .mclr_req    (mclr_req),
    .wdt_expire  (wdt_expire),
    .core_asleep (core_asleep),
    .core_rst    (core_rst),
    .clrwdt_stb  (clrwdt_stb),
    .sleep_stb   (sleep_stb),
    .to_flag     (to_flag),
    .pd_flag     (pd_flag),
    .wdt_clear   (wdt_clear)
  );

  assign boot_pc = RST_VEC;

endmodule

// File: tb/test_rst_cause_ctrl.sv
module test_rst_cause_ctrl;

  localparam int FILT = 3;
  localparam int DL0 = 4, DL1 = 8, DL2 = 12, DL3 = 16;

  logic clk;
  logic por_n, mclr_pin_n, wdt_expire, core_asleep, clrwdt_stb, sleep_stb;
  logic [1:0] osc_kind, start_sel;
  logic core_rst, to_flag, pd_flag, wdt_clear;
  logic [8:0] boot_pc;

  int n_chk = 0, n_bad = 0;
  bit cmp_en = 0;

  rst_cause_ctrl #(
    .SYNC_N(2), .FILT_CYC(FILT), .D_SHORT(DL0), .D_20(DL1), .D_40(DL2), .D_80(DL3)
  ) i_rst_cause_ctrl (
    .clk(clk), .por_n(por_n), .mclr_pin_n(mclr_pin_n), .wdt_expire(wdt_expire),
    .core_asleep(core_asleep), .clrwdt_stb(clrwdt_stb), .sleep_stb(sleep_stb),
    .osc_kind(osc_kind), .start_sel(start_sel), .core_rst(core_rst),
    .to_flag(to_flag), .pd_flag(pd_flag), .wdt_clear(wdt_clear), .boot_pc(boot_pc)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // R7: expected start-up count from oscillator kind and delay code
  function automatic int exp_cnt(int kind, int sel);
    int d [4] = '{DL0, DL1, DL2, DL3};
    int s = sel;
    if (kind == 1 && s < 2) s = 2;
    if ((kind == 2 || kind == 3) && s == 0) s = 1;
    return d[s];
  endfunction

  // Behavioural reference model
  int m_ok1, m_ok2, m_p1, m_p2, m_run, m_mq, m_hold, m_cnt, m_to, m_pd, m_wc;

  task automatic m_clear();
    m_p1 = 1; m_p2 = 1; m_run = 0; m_mq = 0;
    m_hold = 1; m_cnt = 0; m_to = 1; m_pd = 1; m_wc = 0;
  endtask

  always @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      m_ok1 = 0; m_ok2 = 0; m_clear();
    end else if (!m_ok2) begin
      m_ok2 = m_ok1; m_ok1 = 1; m_clear();
    end else begin
      bit mreq, req, rise, wcn;
      int lim;
      mreq = (m_run >= FILT);
      req  = mreq || wdt_expire;
      rise = mreq && !m_mq;
      wcn  = !m_hold && (clrwdt_stb || sleep_stb);
      lim  = exp_cnt(osc_kind, start_sel);
      if (wdt_expire) begin m_to = 0; m_pd = !core_asleep; end
      else if (rise) begin if (core_asleep) begin m_to = 1; m_pd = 0; end end
      else if (!m_hold && clrwdt_stb) begin m_to = 1; m_pd = 1; end
      else if (!m_hold && sleep_stb) begin m_to = 1; m_pd = 0; end
      if (req) begin m_hold = 1; m_cnt = 0; end
      else if (m_hold) begin
        if (m_cnt == lim - 1) m_hold = 0; else m_cnt++;
      end
      if (m_p2 != 0) m_run = 0; else if (m_run < FILT) m_run++;
      m_mq = mreq; m_p2 = m_p1; m_p1 = mclr_pin_n; m_wc = wcn;
    end
  end

  always @(posedge clk) begin
    #3;
    if (cmp_en) begin
      chk("R4 model core_rst", core_rst, m_hold);
      chk("R5 model to_flag", to_flag, m_to);
      chk("R5 model pd_flag", pd_flag, m_pd);
      chk("R8 model wdt_clear", wdt_clear, m_wc);
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic edges_until(logic val, output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (core_rst !== val && n < 1000);
  endtask

  task automatic do_por(int kind, int sel, string tag);
    int n;
    por_n = 0; osc_kind = 2'(kind); start_sel = 2'(sel);
    tick(3);
    por_n = 1;
    edges_until(1'b0, n);
    chk(tag, n, 2 + exp_cnt(kind, sel));
  endtask

  task automatic pulse(ref logic sig);
    sig = 1; tick(1); sig = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int n;
    por_n = 0; mclr_pin_n = 1; wdt_expire = 0; core_asleep = 0;
    clrwdt_stb = 0; sleep_stb = 0; osc_kind = 2'd0; start_sel = 2'd1;
    tick(3);
    cmp_en = 1;
    // R1 reset state, clear strobes ignored during power-on hold
    chk("R1 core_rst", core_rst, 1);
    chk("R1 to_flag", to_flag, 1);
    chk("R1 pd_flag", pd_flag, 1);
    chk("R1 wdt_clear", wdt_clear, 0);
    chk("R11 boot_pc", boot_pc, 9'h1FF);
    // R2 power-on hold length
    do_por(0, 1, "R2 por release edges");
    // R7 promotion cases
    do_por(0, 0, "R7 RC short");
    do_por(1, 0, "R7 LF promoted");
    do_por(1, 3, "R7 LF longest");
    do_por(2, 0, "R7 XT promoted");
    do_por(3, 2, "R7 HF 40");
    do_por(0, 1, "R2 por default");
    tick(2);
    // R9 sleep
    @(negedge clk); sleep_stb = 1; @(negedge clk); sleep_stb = 0;
    chk("R9 to", to_flag, 1); chk("R9 pd", pd_flag, 0); chk("R9 clr", wdt_clear, 1);
    @(negedge clk); chk("R9 clr single", wdt_clear, 0);
    // R8 clrwdt with sleep in same cycle
    clrwdt_stb = 1; sleep_stb = 1; @(negedge clk); clrwdt_stb = 0; sleep_stb = 0;
    chk("R8 to", to_flag, 1); chk("R8 pd", pd_flag, 1); chk("R8 clr", wdt_clear, 1);
    @(negedge clk); chk("R8 clr single", wdt_clear, 0);
    // R6 watchdog while awake
    core_asleep = 0; pulse(wdt_expire);
    chk("R6 core_rst rise", core_rst, 1);
    chk("R6 to awake", to_flag, 0); chk("R6 pd awake", pd_flag, 1);
    // R10 strobes ignored while held
    clrwdt_stb = 1; tick(1); clrwdt_stb = 0;
    chk("R10 to kept", to_flag, 0); chk("R10 pd kept", pd_flag, 1); chk("R10 no clr", wdt_clear, 0);
    sleep_stb = 1; tick(1); sleep_stb = 0;
    chk("R10 pd kept sleep", pd_flag, 1); chk("R10 no clr sleep", wdt_clear, 0);
    edges_until(1'b0, n);
    chk("R6 core_rst held", core_rst, 0);
    tick(2);
    wdt_expire = 1; @(negedge clk); wdt_expire = 0; n = 1;
    while (core_rst !== 1'b0 && n < 1000) begin @(negedge clk); n++; end
    chk("R6 release edges", n, exp_cnt(0, 1) + 1);
    tick(2);
    // R5 master clear awake: flags unchanged (0/1 from watchdog)
    core_asleep = 0; mclr_pin_n = 0;
    edges_until(1'b1, n);
    chk("R4 assert edges", n, FILT + 3);
    chk("R5 to awake kept", to_flag, 0); chk("R5 pd awake kept", pd_flag, 1);
    tick(5);
    mclr_pin_n = 1;
    edges_until(1'b0, n);
    chk("R4 release edges", n, exp_cnt(0, 1) + 3);
    tick(2);
    // R6 watchdog while asleep
    core_asleep = 1; pulse(wdt_expire);
    chk("R6 to asleep", to_flag, 0); chk("R6 pd asleep", pd_flag, 0);
    edges_until(1'b0, n);
    tick(2);
    // R3 short master-clear pulse ignored
    mclr_pin_n = 0; tick(FILT - 1); mclr_pin_n = 1;
    tick(FILT + 6);
    chk("R3 no reset", core_rst, 0);
    chk("R3 to kept", to_flag, 0); chk("R3 pd kept", pd_flag, 0);
    // R5 master clear while asleep
    mclr_pin_n = 0;
    edges_until(1'b1, n);
    chk("R5 to asleep", to_flag, 1); chk("R5 pd asleep", pd_flag, 0);
    mclr_pin_n = 1; core_asleep = 0;
    edges_until(1'b0, n);
    tick(3);
    chk("R11 boot_pc end", boot_pc, 9'h1FF);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule